// File: doc/BRIEF.md
# Four-Event Edge Capture Sequencer

This block records when edges arrive on one capture input. A free-running time base supplies the stamps, and four capture slots hold them. A small modulo sequencer points at the slot that takes the next stamp. Each slot has its own edge direction. Each slot can also clear the time base once its stamp is stored, so the same hardware measures either absolute times or the intervals between edges.

The sequencer has two modes. In wrapping mode it returns to slot 0 after a programmable last slot. In one-shot mode it freezes at that slot and ignores further edges until a rearm strobe. A phase value can be loaded into the time base from an external sync pulse or from a software strobe. A run control freezes or releases the count. A soft-reset strobe gives a clean starting point.

Top module: `edge_capture_seq`

## Requirements
- R1: After reset the time stamp, all four capture slots, the event pulses, the overflow pulse, the slot pointer and the frozen flag are all zero.
- R2: An accepted edge stores into the slot named by `seq_ptr`. One cycle later, bit i of `evt_pulse` pulses for slot i. The pointer then advances by one.
- R3: Bit i of `cfg_pol` selects the edge for slot i: 0 is a rising edge and 1 is a falling edge. An edge of the other direction produces no event.
- R4: The stored stamp equals the value `tstamp` held in the cycle in which the input changed.
- R5: When bit i of `cfg_ctr_rst` is set, an event on slot i makes `tstamp` read 0 in the next cycle. The next event therefore stores the edge spacing minus one.
- R6: When a slot clears the counter, the value it stores is the count before the clear, not zero.
- R7: In wrapping mode (`cfg_oneshot`=0), an event on slot `cfg_stop` returns the pointer to 0. Slots above `cfg_stop` keep their contents.
- R8: In one-shot mode (`cfg_oneshot`=1), an event on slot `cfg_stop` raises `seq_frozen` and the pointer stays there. While frozen, edges produce no pulse and store nothing.
- R9: A `rearm` strobe sets the pointer to 0 and clears `seq_frozen`. The next edge then loads slot 0.
- R10: With `cfg_load_en`=0, events still pulse and advance the pointer, but the capture slots keep their values.
- R11: With `cfg_sync_en`=1, a `sync_in` or `sw_sync` pulse loads `cfg_phase` into the time stamp in the next cycle. With `cfg_sync_en`=0 the pulse has no effect.
- R12: `ovf_pulse` is high for exactly the one cycle in which the count has just rolled from all ones to zero.
- R13: With `cfg_run`=0 the time stamp holds its value. With `cfg_run`=1 it rises by one per cycle.
- R14: A `soft_rst` strobe zeroes the time stamp and the pointer, clears `seq_frozen`, and suppresses any event in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | 1 | Conditioned, synchronous capture signal |
| sync_in | input | 1 | External phase-load pulse |
| cfg_pol | input | NSLOT | Edge direction per slot (1 = falling) |
| cfg_ctr_rst | input | NSLOT | Clear the counter after this slot's stamp |
| cfg_stop | input | PW | Last slot before wrap or freeze |
| cfg_oneshot | input | 1 | 1 = one-shot, 0 = wrapping |
| cfg_load_en | input | 1 | Allow stamps to be stored |
| cfg_run | input | 1 | 1 = time base counts |
| cfg_sync_en | input | 1 | Allow phase loads |
| cfg_phase | input | TW | Phase value for the time base |
| sw_sync | input | 1 | Software phase-load strobe |
| rearm | input | 1 | Restart a frozen one-shot sequence |
| soft_rst | input | 1 | Clear counter, sequencer and pending events |
| cap_flat | output | NSLOT*TW | Capture slots, slot i at bits i*TW upward |
| evt_pulse | output | NSLOT | One-cycle event pulse per slot |
| ovf_pulse | output | 1 | Time base rolled over |
| tstamp | output | TW | Current time base value |
| seq_ptr | output | PW | Slot that takes the next stamp |
| seq_frozen | output | 1 | One-shot sequence has stopped |

## Verification
The properties assume that `cap_in` is already synchronous to `clk`, so an edge is a change between two consecutive samples. They also assume the strobes are single-cycle pulses. Priority is taken as given: soft reset over phase load, phase load over the event clear, and the event clear over counting. The bench changes every input just after the falling clock edge. It raises each strobe for one cycle only and keeps the capture input steady for at least one cycle between changes, so every transition is seen once.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

  typedef enum logic {
    SEQ_WRAP = 1'b0,
    SEQ_ONCE = 1'b1
  } seq_mode_e;

  // Edge match for one slot: falling=1 selects a high-to-low change.
  function automatic logic edge_match(input logic now, input logic prev, input logic falling);
    return falling ? (prev & ~now) : (now & ~prev);
  endfunction

endpackage

// File: rtl/ecs_edge.sv
module ecs_edge #(
  parameter int NSLOT = 4,
  parameter int PW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_in,
  input  logic [NSLOT-1:0] pol,
  input  logic [PW-1:0]    ptr,
  output logic             match
);
  import ecs_pkg::*;

  logic cap_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_prev <= 1'b0;
    else        cap_prev <= cap_in;
  end

  // Only the polarity of the slot being pointed at matters.
  assign match = edge_match(cap_in, cap_prev, pol[ptr]);

endmodule

// File: rtl/ecs_seq.sv
module ecs_seq #(
  parameter int NSLOT = 4,
  parameter int PW    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_clr,
  input  logic                rearm,
  input  logic                match,
  input  logic [PW-1:0]       stop,
  input  ecs_pkg::seq_mode_e  mode,
  output logic [PW-1:0]       ptr,
  output logic                frozen,
  output logic                hit,
  output logic                last
);
  import ecs_pkg::*;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return p + PW'(1);
  endfunction

  assign last = (ptr == stop);
  assign hit  = match & ~frozen & ~rearm & ~soft_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      frozen <= 1'b0;
    end else if (soft_clr || rearm) begin
      ptr    <= '0;
      frozen <= 1'b0;
    end else if (hit) begin
      if (!last)                 ptr    <= step_ptr(ptr);
      else if (mode == SEQ_ONCE) frozen <= 1'b1;
      else                       ptr    <= '0;
    end
  end

endmodule

// File: rtl/ecs_timebase.sv
module ecs_timebase #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_clr,
  input  logic          sync_ld,
  input  logic [TW-1:0] phase,
  input  logic          zero_req,
  input  logic          run,
  output logic [TW-1:0] count,
  output logic          ovf_pulse
);

  logic at_top;
  assign at_top = &count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= 1'b0;
      if (soft_clr)      count <= '0;
      else if (sync_ld)  count <= phase;
      else if (zero_req) count <= '0;
      else if (run) begin
        count     <= count + TW'(1);
        ovf_pulse <= at_top;
      end
    end
  end

endmodule

// File: rtl/edge_capture_seq.sv
module edge_capture_seq #(
  parameter int NSLOT = 4,
  parameter int TW    = 32,
  localparam int PW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_in,
  input  logic                sync_in,
  input  logic [NSLOT-1:0]    cfg_pol,
  input  logic [NSLOT-1:0]    cfg_ctr_rst,
  input  logic [PW-1:0]       cfg_stop,
  input  logic                cfg_oneshot,
  input  logic                cfg_load_en,
  input  logic                cfg_run,
  input  logic                cfg_sync_en,
  input  logic [TW-1:0]       cfg_phase,
  input  logic                sw_sync,
  input  logic                rearm,
  input  logic                soft_rst,
  output logic [NSLOT*TW-1:0] cap_flat,
  output logic [NSLOT-1:0]    evt_pulse,
  output logic                ovf_pulse,
  output logic [TW-1:0]       tstamp,
  output logic [PW-1:0]       seq_ptr,
  output logic                seq_frozen
);
  import ecs_pkg::*;

  function automatic logic [NSLOT-1:0] slot_mask(input logic [PW-1:0] s);
    logic [NSLOT-1:0] m;
    m    = '0;
    m[s] = 1'b1;
    return m;
  endfunction

  // Named internal events, visible to the bound checker.
  logic      match;
  logic      hit;
  logic      last;
  logic      zero_req;
  logic      sync_ld;
  seq_mode_e mode;

  assign mode     = cfg_oneshot ? SEQ_ONCE : SEQ_WRAP;
  assign sync_ld  = cfg_sync_en & (sync_in | sw_sync);
  assign zero_req = hit & cfg_ctr_rst[seq_ptr];

  ecs_edge #(.NSLOT(NSLOT), .PW(PW)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_in (cap_in),
    .pol    (cfg_pol),
    .ptr    (seq_ptr),
    .match  (match)
  );

  ecs_seq #(.NSLOT(NSLOT), .PW(PW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_rst),
    .rearm    (rearm),
    .match    (match),
    .stop     (cfg_stop),
    .mode     (mode),
    .ptr      (seq_ptr),
    .frozen   (seq_frozen),
    .hit      (hit),
    .last     (last)
  );

  ecs_timebase #(.TW(TW)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (soft_rst),
    .sync_ld   (sync_ld),
    .phase     (cfg_phase),
    .zero_req  (zero_req),
    .run       (cfg_run),
    .count     (tstamp),
    .ovf_pulse (ovf_pulse)
  );

  // Capture slots: each stores the pre-update count of its event cycle.
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [TW-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q <= '0;
      else if (hit && cfg_load_en && (seq_ptr == PW'(g)))
        slot_q <= tstamp;
    end
    assign cap_flat[g*TW +: TW] = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   evt_pulse <= '0;
    else if (hit) evt_pulse <= slot_mask(seq_ptr);
    else          evt_pulse <= '0;
  end

endmodule

// File: rtl/ecs_checker.sv
module ecs_checker #(
  parameter int NSLOT = 4,
  parameter int TW    = 32,
  parameter int PW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_oneshot,
  input logic [PW-1:0]    cfg_stop,
  input logic [NSLOT-1:0] cfg_ctr_rst,
  input logic [TW-1:0]    cfg_phase,
  input logic             soft_rst,
  input logic             rearm,
  input logic             sync_ld,
  input logic             hit,
  input logic [PW-1:0]    seq_ptr,
  input logic             seq_frozen,
  input logic [TW-1:0]    tstamp,
  input logic             ovf_pulse,
  input logic [NSLOT-1:0] evt_pulse
);

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (tstamp == '0 || !rst_n)); // R1
  AST_EVT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(evt_pulse)); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    hit && (seq_ptr != cfg_stop) |=> seq_ptr == PW'($past(seq_ptr) + 1'b1)); // R2
  AST_CLEAR_AFTER_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    hit && cfg_ctr_rst[seq_ptr] && !soft_rst && !sync_ld |=> tstamp == '0); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !cfg_oneshot && (seq_ptr == cfg_stop) |=> seq_ptr == '0); // R7
  AST_ONESHOT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hit && cfg_oneshot && (seq_ptr == cfg_stop) |=> seq_frozen && $stable(seq_ptr)); // R8
  AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    seq_frozen && !rearm && !soft_rst |=> $stable(seq_ptr) && evt_pulse == '0); // R8
  AST_REARM_START: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> seq_ptr == '0 && !seq_frozen); // R9
  AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ld && !soft_rst |=> tstamp == $past(cfg_phase)); // R11
  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> tstamp == '0); // R12
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> tstamp == '0 && seq_ptr == '0 && evt_pulse == '0 && !seq_frozen); // R14

endmodule

bind edge_capture_seq ecs_checker #(.NSLOT(NSLOT), .TW(TW), .PW(PW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_oneshot (cfg_oneshot),
  .cfg_stop    (cfg_stop),
  .cfg_ctr_rst (cfg_ctr_rst),
  .cfg_phase   (cfg_phase),
  .soft_rst    (soft_rst),
  .rearm       (rearm),
  .sync_ld     (sync_ld),
  .hit         (hit),
  .seq_ptr     (seq_ptr),
  .seq_frozen  (seq_frozen),
  .tstamp      (tstamp),
  .ovf_pulse   (ovf_pulse),
  .evt_pulse   (evt_pulse)
);

// File: tb/sim_edge_capture_seq.sv
module sim_edge_capture_seq;
  localparam int NSLOT = 4;
  localparam int TW    = 32;
  localparam int PW    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             cap_in = 1'b0, sync_in = 1'b0, sw_sync = 1'b0;
  logic             rearm = 1'b0, soft_rst = 1'b0;
  logic [NSLOT-1:0] cfg_pol = '0, cfg_ctr_rst = '0;
  logic [PW-1:0]    cfg_stop = 2'd3;
  logic             cfg_oneshot = 1'b0, cfg_load_en = 1'b1, cfg_run = 1'b0, cfg_sync_en = 1'b0;
  logic [TW-1:0]    cfg_phase = '0;

  logic [NSLOT*TW-1:0] cap_flat;
  logic [NSLOT-1:0]    evt_pulse;
  logic                ovf_pulse;
  logic [TW-1:0]       tstamp;
  logic [PW-1:0]       seq_ptr;
  logic                seq_frozen;

  int n_chk = 0;
  int n_fail = 0;

  edge_capture_seq #(.NSLOT(NSLOT), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .sync_in(sync_in),
    .cfg_pol(cfg_pol), .cfg_ctr_rst(cfg_ctr_rst), .cfg_stop(cfg_stop),
    .cfg_oneshot(cfg_oneshot), .cfg_load_en(cfg_load_en), .cfg_run(cfg_run),
    .cfg_sync_en(cfg_sync_en), .cfg_phase(cfg_phase), .sw_sync(sw_sync),
    .rearm(rearm), .soft_rst(soft_rst), .cap_flat(cap_flat),
    .evt_pulse(evt_pulse), .ovf_pulse(ovf_pulse), .tstamp(tstamp),
    .seq_ptr(seq_ptr), .seq_frozen(seq_frozen)
  );

  function automatic logic [TW-1:0] slot(input int i);
    return cap_flat[i*TW +: TW];
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Called just after a falling edge: drive the input, note the count it will stamp.
  task automatic set_in(input logic v, input int hold, output logic [TW-1:0] snap, output logic [NSLOT-1:0] ev);
    cap_in = v;
    snap = tstamp;
    @(negedge clk);
    ev = evt_pulse;
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic fire(input int k, output logic [TW-1:0] snap, output logic [NSLOT-1:0] ev);
    logic [TW-1:0] s2;
    logic [NSLOT-1:0] e2;
    set_in(1'b1, 1, snap, ev);
    set_in(1'b0, k - 1, s2, e2);
  endtask

  task automatic do_soft();
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < NSLOT; i++) check("R1", "slot after reset", slot(i), 0);
    check("R1", "tstamp", tstamp, 0);
    check("R1", "ptr/frozen/evt/ovf", {seq_ptr, seq_frozen, evt_pulse, ovf_pulse}, 0);
  endtask

  task automatic t_absolute();
    logic [TW-1:0] s [NSLOT];
    logic [NSLOT-1:0] e;
    cfg_run = 1'b1; cfg_ctr_rst = '0; cfg_pol = '0; cfg_stop = 2'd3; cfg_oneshot = 1'b0;
    do_soft();
    check("R14", "tstamp after soft reset", tstamp, 0);
    repeat (2) @(negedge clk);
    for (int i = 0; i < NSLOT; i++) begin
      check("R2", "pointer before event", seq_ptr, i);
      fire(3, s[i], e);
      check("R2", "event pulse bit", e, 1 << i);
    end
    for (int i = 0; i < NSLOT; i++) check("R4", "absolute stamp", slot(i), s[i]);
    check("R7", "wrap after slot 3", seq_ptr, 0);
  endtask

  task automatic t_polarity();
    logic [TW-1:0] s;
    logic [NSLOT-1:0] e;
    cfg_pol = 4'b1010;
    do_soft();
    set_in(1'b1, 3, s, e); check("R3", "slot0 rising", e, 4'b0001); check("R3", "slot0 stamp", slot(0), s);
    set_in(1'b0, 3, s, e); check("R3", "slot1 falling", e, 4'b0010); check("R3", "slot1 stamp", slot(1), s);
    cfg_pol = 4'b1111;
    do_soft();
    set_in(1'b1, 3, s, e); check("R3", "rising ignored on falling slot", e, 0);
    check("R3", "pointer unchanged", seq_ptr, 0);
    set_in(1'b0, 3, s, e); check("R3", "falling accepted", e, 4'b0001);
    cfg_pol = '0;
  endtask

  task automatic t_delta();
    logic [TW-1:0] s, d;
    logic [NSLOT-1:0] e;
    cfg_ctr_rst = 4'hF; cfg_stop = 2'd3; cfg_oneshot = 1'b0;
    do_soft();
    repeat (4) @(negedge clk);
    set_in(1'b1, 1, s, e);
    check("R5", "count cleared after event", tstamp, 0);
    set_in(1'b0, 5, d, e);
    check("R6", "pre-clear stamp kept", slot(0), s);
    fire(5, s, e);
    fire(4, s, e);
    fire(3, s, e);
    check("R5", "delta slot1", slot(1), 5);
    check("R5", "delta slot2", slot(2), 4);
    check("R5", "delta slot3", slot(3), 3);
    cfg_ctr_rst = '0;
  endtask

  task automatic t_short_wrap();
    logic [TW-1:0] s, s0, keep2;
    logic [NSLOT-1:0] e;
    cfg_stop = 2'd1;
    do_soft();
    keep2 = slot(2);
    fire(3, s0, e);
    fire(3, s, e); check("R7", "second pulse", e, 4'b0010);
    fire(3, s0, e); check("R7", "third event back at slot0", e, 4'b0001);
    check("R7", "slot0 overwritten", slot(0), s0);
    check("R7", "slot2 untouched", slot(2), keep2);
    check("R7", "pointer", seq_ptr, 1);
  endtask

  task automatic t_oneshot();
    logic [TW-1:0] s, keep0;
    logic [NSLOT-1:0] e;
    cfg_stop = 2'd2; cfg_oneshot = 1'b1;
    do_soft();
    for (int i = 0; i < 3; i++) fire(3, s, e);
    check("R8", "frozen", seq_frozen, 1);
    check("R8", "pointer held at stop", seq_ptr, 2);
    keep0 = slot(0);
    fire(3, s, e);
    check("R8", "no pulse while frozen", e, 0);
    check("R8", "slot2 unchanged while frozen", slot(2) == s, 0);
    check("R8", "pointer still held", seq_ptr, 2);
    rearm = 1'b1; @(negedge clk); rearm = 1'b0;
    check("R9", "ptr/frozen after rearm", {seq_ptr, seq_frozen}, 0);
    fire(3, s, e);
    check("R9", "pulse after rearm", e, 4'b0001);
    check("R9", "slot0 reloaded", slot(0), s);
    cfg_oneshot = 1'b0;
    check("R9", "slot0 changed", slot(0) == keep0, 0);
  endtask

  task automatic t_load_gate();
    logic [TW-1:0] s, keep0;
    logic [NSLOT-1:0] e;
    cfg_stop = 2'd3; cfg_load_en = 1'b0;
    do_soft();
    keep0 = slot(0);
    repeat (3) @(negedge clk);
    fire(3, s, e);
    check("R10", "pulse with loads off", e, 4'b0001);
    check("R10", "pointer advanced", seq_ptr, 1);
    check("R10", "slot0 kept", slot(0), keep0);
    cfg_load_en = 1'b1;
  endtask

  task automatic t_sync_run_ovf();
    logic [TW-1:0] c;
    cfg_sync_en = 1'b1; cfg_phase = 32'd1000;
    sync_in = 1'b1; @(negedge clk); sync_in = 1'b0;
    check("R11", "phase from sync_in", tstamp, 1000);
    cfg_sync_en = 1'b0; cfg_phase = 32'd5;
    c = tstamp;
    sync_in = 1'b1; @(negedge clk); sync_in = 1'b0;
    check("R11", "sync ignored when disabled", tstamp, c + 1);
    cfg_run = 1'b0; @(negedge clk);
    c = tstamp;
    repeat (5) @(negedge clk);
    check("R13", "held while stopped", tstamp, c);
    cfg_run = 1'b1; @(negedge clk);
    check("R13", "counts once running", tstamp, c + 1);
    cfg_sync_en = 1'b1; cfg_phase = 32'hFFFF_FFFD;
    sw_sync = 1'b1; @(negedge clk); sw_sync = 1'b0;
    check("R11", "phase from sw_sync", tstamp, 32'hFFFF_FFFD);
    @(negedge clk); check("R12", "no ovf at FFFFFFFE", ovf_pulse, 0);
    @(negedge clk); check("R12", "no ovf at FFFFFFFF", {ovf_pulse, tstamp}, {1'b0, 32'hFFFF_FFFF});
    @(negedge clk); check("R12", "ovf on rollover", {ovf_pulse, tstamp}, {1'b1, 32'h0});
    @(negedge clk); check("R12", "ovf one cycle", {ovf_pulse, tstamp}, {1'b0, 32'h1});
    cfg_sync_en = 1'b0;
  endtask

  task automatic t_soft_frozen();
    logic [TW-1:0] s;
    logic [NSLOT-1:0] e;
    cfg_oneshot = 1'b1; cfg_stop = 2'd0;
    do_soft();
    fire(3, s, e);
    check("R8", "frozen at stop 0", seq_frozen, 1);
    cap_in = 1'b1; soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    check("R14", "soft reset clears freeze", {seq_ptr, seq_frozen, evt_pulse}, 0);
    check("R14", "count zero", tstamp, 0);
    cap_in = 1'b0; cfg_oneshot = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_absolute();
    t_polarity();
    t_delta();
    t_short_wrap();
    t_oneshot();
    t_load_gate();
    t_sync_run_ovf();
    t_soft_frozen();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule